// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O SRAM With Same-Cycle Forwarding

This block is a synthesizable behavioural model of a static memory with separate read and write paths. In every main clock cycle it can take one read command and one write command, each with its own burst address. A burst address names a pair of words, and each command moves both of them: an even word (beat 0) and an odd word (beat 1). On the write side, each beat has its own byte enables, which are active low.

Read data comes back a fixed two cycles after the command, with both beats presented side by side and qualified by a single valid flag. Reads always see writes that finished in earlier cycles. The block also handles the case where the read and the write in one cycle name the same burst address. In that case the read returns the bytes being written in that same cycle. Any byte whose write enable is off keeps the value that was stored before. Between read results, the data outputs hold their last value.

Top module: `burst2_sram`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rd_valid` and both read data outputs are cleared to zero at that edge.
- R2: `rd_valid` is high for exactly the one cycle that follows the second rising edge after a read command is sampled, and it is low when no read was sampled two edges earlier.
- R3: A read and a write to different burst addresses in the same cycle are both carried out.
- R4: Beat 0 (`wr_data0`, `rd_data0`) is the even word and beat 1 (`wr_data1`, `rd_data1`) is the odd word of a burst address. The two words are stored independently.
- R5: Byte enables are active low. Bit i of `wr_be_n0` or `wr_be_n1` governs data bits [i*9 +: 9] of its beat, with byte 0 in the low bits. Bytes whose enable bit is 1 keep their old stored value.
- R6: A read of an address written in any earlier cycle, including the immediately preceding cycle, returns the written data.
- R7: When the read and the write in one cycle share a burst address, each enabled byte of the returned data is the incoming write byte.
- R8: In such a same-address cycle, each byte whose enable bit is 1 returns the value stored before that cycle. This includes the case where every byte is disabled.
- R9: When the read and write addresses differ, the read returns the stored contents, unaffected by the same-cycle write.
- R10: A write to the same address in the cycle after a read does not change the data that read returns.
- R11: While `rd_valid` is low, `rd_data0` and `rd_data1` hold the value of the most recent read result.
- R12: With `wr_en` low, the write address, data and enables change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read pipeline |
| rd_en | input | 1 | Read command strobe, active high |
| rd_addr | input | ADDR_W | Burst address of the read |
| wr_en | input | 1 | Write command strobe, active high |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_data0 | input | BYTE_W*NUM_BYTES | Write data, beat 0 (even word) |
| wr_data1 | input | BYTE_W*NUM_BYTES | Write data, beat 1 (odd word) |
| wr_be_n0 | input | NUM_BYTES | Active-low byte enables for beat 0 |
| wr_be_n1 | input | NUM_BYTES | Active-low byte enables for beat 1 |
| rd_data0 | output | BYTE_W*NUM_BYTES | Read data, beat 0 (even word) |
| rd_data1 | output | BYTE_W*NUM_BYTES | Read data, beat 1 (odd word) |
| rd_valid | output | 1 | Marks both read beats as valid |

## Verification
Some properties are checked by assertions on every cycle. These are the read-valid pipeline timing, and the rule that a forward mask only appears alongside a pending read and never for differing addresses. The assertions also cover the per-byte choice between forwarded write bytes and stored bytes, and the holding of the output data between results. Other behaviour can only be shown by the bench's scenarios, because it depends on the stored contents over several commands. This covers coherence with earlier writes, the mapping of beats to even and odd words, the effect of disabled byte enables on what is stored, an ignored write strobe, and a write landing just after a read.

// File: rtl/burst2_pkg.sv
`timescale 1ns/1ps
// Shared constants for the burst-of-two memory model.
// Assumes every command carries exactly two beats: even word first, odd word second.
package burst2_pkg;
    localparam int BEATS = 2;

    // Bit offset of a beat inside a lane that packs all beats low-to-high.
    function automatic int beat_base(input int beat, input int word_w);
        return beat * word_w;
    endfunction
endpackage

// File: rtl/burst2_bank.sv
`timescale 1ns/1ps
// One word bank (all even words or all odd words) of the burst memory.
// Writes land at the rising edge with active-low byte enables. The read is
// synchronous, so a read and a write to the same row at one edge return the
// old row contents. Storage is never reset, as in a real memory array.
module burst2_bank #(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W*NUM_BYTES-1:0] wr_data,
    input  logic [NUM_BYTES-1:0]        wr_be_n,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W*NUM_BYTES-1:0] rd_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = BYTE_W * NUM_BYTES;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store each enabled byte of the incoming word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (!wr_be_n[b]) begin
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Fetch the addressed row when a read is issued.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/burst2_fwd.sv
`timescale 1ns/1ps
// Collision capture stage. It registers the read strobe and detects a read and a
// write to the same burst address in one cycle. For such a cycle it keeps the
// write bytes together with a per-byte forward mask, so the read can take them
// instead of the stored row. Assumes lanes pack beats low-to-high, bytes
// low-to-high inside each beat.
module burst2_fwd #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 36,
    parameter int LANE_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_word,
    input  logic [LANE_B-1:0] wr_ben,
    output logic              s1_vld,
    output logic [LANE_B-1:0] s1_mask,
    output logic [LANE_W-1:0] s1_data
);
    logic same_slot;

    // A collision needs both strobes and equal burst addresses.
    always_comb begin
        same_slot = rd_en && wr_en && (rd_addr == wr_addr);
    end

    // Register the read strobe, the forward mask and the write bytes to forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_mask <= '0;
            s1_data <= '0;
        end else begin
            s1_vld  <= rd_en;
            s1_mask <= same_slot ? ~wr_ben : '0;
            if (same_slot) begin
                s1_data <= wr_word;
            end
        end
    end

    assert_read_tracked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> s1_vld);
    assert_idle_tracked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !s1_vld);
    assert_mask_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_mask != '0) |-> s1_vld);
    assert_no_fwd_other_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && (rd_addr != wr_addr)) |=> (s1_mask == '0));
endmodule

// File: rtl/burst2_merge.sv
`timescale 1ns/1ps
// Output stage. For each byte it picks either the forwarded write byte or the
// stored byte, and registers the result with the valid flag. The data holds
// between read results. Assumes mem_q is valid in any cycle where s1_vld is high.
module burst2_merge #(
    parameter int BYTE_W = 9,
    parameter int LANE_B = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_vld,
    input  logic [LANE_B-1:0]        s1_mask,
    input  logic [BYTE_W*LANE_B-1:0] s1_data,
    input  logic [BYTE_W*LANE_B-1:0] mem_q,
    output logic [BYTE_W*LANE_B-1:0] rd_word,
    output logic                     rd_valid
);
    localparam int LANE_W = BYTE_W * LANE_B;

    logic [LANE_W-1:0] merged;

    for (genvar g = 0; g < LANE_B; g++) begin : g_byte
        // Choose the forwarded byte when its mask bit is set.
        assign merged[g*BYTE_W +: BYTE_W] = s1_mask[g] ? s1_data[g*BYTE_W +: BYTE_W]
                                                       : mem_q[g*BYTE_W +: BYTE_W];

        assert_fwd_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_vld && s1_mask[g]) |=>
                (rd_word[g*BYTE_W +: BYTE_W] == $past(s1_data[g*BYTE_W +: BYTE_W])));
        assert_kept_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_vld && !s1_mask[g]) |=>
                (rd_word[g*BYTE_W +: BYTE_W] == $past(mem_q[g*BYTE_W +: BYTE_W])));
    end

    // Register the result; the data changes only when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= s1_vld;
            if (s1_vld) begin
                rd_word <= merged;
            end
        end
    end

    assert_valid_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> rd_valid);
    assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> (!rd_valid && $stable(rd_word)));
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
// Burst-of-two separate-I/O memory model. Each cycle it takes one read and one
// write command. Each command covers an even word and an odd word of a burst
// address. Read data returns two cycles later, and same-cycle same-address
// writes are forwarded byte by byte. Assumes the read data of locations never
// written is don't-care.
module burst2_sram #(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W*NUM_BYTES-1:0] wr_data0,
    input  logic [BYTE_W*NUM_BYTES-1:0] wr_data1,
    input  logic [NUM_BYTES-1:0]        wr_be_n0,
    input  logic [NUM_BYTES-1:0]        wr_be_n1,
    output logic [BYTE_W*NUM_BYTES-1:0] rd_data0,
    output logic [BYTE_W*NUM_BYTES-1:0] rd_data1,
    output logic                        rd_valid
);
    import burst2_pkg::*;

    localparam int WORD_W = BYTE_W * NUM_BYTES;
    localparam int LANE_W = BEATS * WORD_W;
    localparam int LANE_B = BEATS * NUM_BYTES;

    logic [LANE_W-1:0] wr_word;
    logic [LANE_B-1:0] wr_ben;
    logic [LANE_W-1:0] mem_q;
    logic [LANE_W-1:0] rd_word;
    logic              s1_vld;
    logic [LANE_B-1:0] s1_mask;
    logic [LANE_W-1:0] s1_data;

    // Pack both beats into one lane, even word in the low half.
    always_comb begin
        wr_word = {wr_data1, wr_data0};
        wr_ben  = {wr_be_n1, wr_be_n0};
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_bank
        burst2_bank #(
            .ADDR_W   (ADDR_W),
            .BYTE_W   (BYTE_W),
            .NUM_BYTES(NUM_BYTES)
        ) u_bank (
            .clk    (clk),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_word[beat_base(b, WORD_W) +: WORD_W]),
            .wr_be_n(wr_ben[b*NUM_BYTES +: NUM_BYTES]),
            .rd_en  (rd_en),
            .rd_addr(rd_addr),
            .rd_q   (mem_q[beat_base(b, WORD_W) +: WORD_W])
        );
    end

    burst2_fwd #(
        .ADDR_W(ADDR_W),
        .LANE_W(LANE_W),
        .LANE_B(LANE_B)
    ) u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_word(wr_word),
        .wr_ben (wr_ben),
        .s1_vld (s1_vld),
        .s1_mask(s1_mask),
        .s1_data(s1_data)
    );

    burst2_merge #(
        .BYTE_W(BYTE_W),
        .LANE_B(LANE_B)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .s1_vld  (s1_vld),
        .s1_mask (s1_mask),
        .s1_data (s1_data),
        .mem_q   (mem_q),
        .rd_word (rd_word),
        .rd_valid(rd_valid)
    );

    // Split the registered lane back into the two beat outputs.
    always_comb begin
        rd_data0 = rd_word[WORD_W-1:0];
        rd_data1 = rd_word[LANE_W-1:WORD_W];
    end
endmodule

// File: tb/burst2_sram_test.sv
`timescale 1ns/1ps
// Self-checking bench: a stimulus table walked by one loop against a bench-side
// memory model, then directed reset checks.
module burst2_sram_test;
    localparam int AW = 8;
    localparam int BW = 9;
    localparam int NB = 2;
    localparam int DW = BW * NB;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] ra;
        logic          wr;
        logic [AW-1:0] wa;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [NB-1:0] b0;
        logic [NB-1:0] b1;
        logic [3:0]    tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 1'b1, 8'h10, 18'h01111, 18'h02222, 2'b00, 2'b00, 4'd4},
        '{1'b1, 8'h10, 1'b1, 8'h20, 18'h0ABCD, 18'h3F00F, 2'b00, 2'b00, 4'd4},  // R4 beat mapping
        '{1'b1, 8'h20, 1'b1, 8'h30, 18'h01234, 18'h04321, 2'b00, 2'b00, 4'd3},  // R3 both commands
        '{1'b1, 8'h30, 1'b1, 8'h30, 18'h15555, 18'h2AAAA, 2'b00, 2'b00, 4'd7},  // R7 full forward
        '{1'b1, 8'h30, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd6},  // R6 back-to-back
        '{1'b1, 8'h30, 1'b1, 8'h30, 18'h3FFFF, 18'h00000, 2'b10, 2'b01, 4'd8},  // R8 partial forward
        '{1'b1, 8'h30, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd5},  // R5 partial store
        '{1'b1, 8'h20, 1'b1, 8'h10, 18'h00ABC, 18'h00DEF, 2'b00, 2'b00, 4'd9},  // R9 other address
        '{1'b1, 8'h10, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd10}, // R10 read before write
        '{1'b0, 8'h00, 1'b1, 8'h10, 18'h12345, 18'h0F0F0, 2'b00, 2'b00, 4'd11},
        '{1'b0, 8'h00, 1'b0, 8'h10, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, 4'd11},
        '{1'b1, 8'h10, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd12}, // R12 strobe off
        '{1'b0, 8'h00, 1'b1, 8'hFF, 18'h3FFFF, 18'h00001, 2'b00, 2'b00, 4'd11},
        '{1'b1, 8'hFF, 1'b1, 8'hFF, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd8},  // R8 nothing enabled
        '{1'b1, 8'hFF, 1'b1, 8'hFF, 18'h2F0F0, 18'h10101, 2'b01, 2'b10, 4'd7},  // R7 mixed bytes
        '{1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd11}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data0 = '0;
    logic [DW-1:0] wr_data1 = '0;
    logic [NB-1:0] wr_be_n0 = '1;
    logic [NB-1:0] wr_be_n1 = '1;
    logic [DW-1:0] rd_data0;
    logic [DW-1:0] rd_data1;
    logic          rd_valid;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [DW-1:0] m0 [1<<AW];
    logic [DW-1:0] m1 [1<<AW];
    logic          ev  [NV];
    logic [DW-1:0] ed0 [NV];
    logic [DW-1:0] ed1 [NV];
    logic [DW-1:0] last0 = '0;
    logic [DW-1:0] last1 = '0;

    burst2_sram #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data0(wr_data0), .wr_data1(wr_data1),
        .wr_be_n0(wr_be_n0), .wr_be_n1(wr_be_n1),
        .rd_data0(rd_data0), .rd_data1(rd_data1), .rd_valid(rd_valid)
    );

    always #2ns clk = ~clk;

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            4'd11:   return "R11";
            4'd12:   return "R12";
            default: return "R?";
        endcase
    endfunction

    // Byte-wise merge: active-low enable picks the new byte.
    function automatic logic [DW-1:0] bmerge(input logic [DW-1:0] old_w,
                                             input logic [DW-1:0] new_w,
                                             input logic [NB-1:0] be_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < NB; i++) begin
            if (!be_n[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_en = 1'b0; wr_en = 1'b0; rd_addr = '0; wr_addr = '0;
        wr_data0 = '0; wr_data1 = '0; wr_be_n0 = '1; wr_be_n1 = '1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) begin
            m0[a] = '0;
            m1[a] = '0;
        end
        // R1: outputs cleared while reset is held.
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", {17'b0, rd_valid}, '0);
        chk("R1", "data0 in reset", rd_data0, '0);
        chk("R1", "data1 in reset", rd_data1, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                // R2: valid exactly two edges after a sampled read.
                chk("R2", "valid", {17'b0, rd_valid}, {17'b0, ev[i-2]});
                if (ev[i-2]) begin
                    chk(tname(VEC[i-2].tag), "beat0", rd_data0, ed0[i-2]);
                    chk(tname(VEC[i-2].tag), "beat1", rd_data1, ed1[i-2]);
                    last0 = ed0[i-2];
                    last1 = ed1[i-2];
                end else begin
                    chk("R11", "hold beat0", rd_data0, last0);
                    chk("R11", "hold beat1", rd_data1, last1);
                end
            end
            if (i < NV) begin
                rd_en = VEC[i].rd;  rd_addr = VEC[i].ra;
                wr_en = VEC[i].wr;  wr_addr = VEC[i].wa;
                wr_data0 = VEC[i].d0; wr_data1 = VEC[i].d1;
                wr_be_n0 = VEC[i].b0; wr_be_n1 = VEC[i].b1;
                ev[i] = VEC[i].rd;
                ed0[i] = m0[VEC[i].ra];
                ed1[i] = m1[VEC[i].ra];
                if (VEC[i].wr && VEC[i].rd && (VEC[i].wa == VEC[i].ra)) begin
                    ed0[i] = bmerge(ed0[i], VEC[i].d0, VEC[i].b0);
                    ed1[i] = bmerge(ed1[i], VEC[i].d1, VEC[i].b1);
                end
                if (VEC[i].wr) begin
                    m0[VEC[i].wa] = bmerge(m0[VEC[i].wa], VEC[i].d0, VEC[i].b0);
                    m1[VEC[i].wa] = bmerge(m1[VEC[i].wa], VEC[i].d1, VEC[i].b1);
                end
            end else begin
                idle_inputs();
            end
        end

        // R1: reset in mid-flow with a read pending clears the outputs.
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h30;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "valid after mid reset", {17'b0, rd_valid}, '0);
        chk("R1", "data0 after mid reset", rd_data0, '0);
        chk("R1", "data1 after mid reset", rd_data1, '0);
        idle_inputs();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2", "no valid without read", {17'b0, rd_valid}, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule